// File: doc/BRIEF.md
# Query-Based Victim Selector for an Inclusive Last-Level Cache Set

On a miss to one set of an inclusive last-level cache, this block chooses which way to evict. It tries to avoid ways whose block is still held in some core's private cache, because evicting such a block forces a back-invalidate of data that the core is still using. The block tracks a full recency order for the set. On a miss it takes the least recently used way as a candidate and asks every core cache whether it holds that tag. If any core says yes, the candidate moves to the most-recent position and the new least-recent way is asked about next. A way that no core holds becomes the victim.

The number of queries per miss is bounded by the `query_cap` input. The usual setting is 2, which keeps the selection short enough to finish while the memory fetch is in flight. When the cap runs out, the way that is least recent at that moment is evicted and flagged for back-invalidation. An invalid way in the set is always taken first, with no query. The chosen victim is then treated as filled and becomes most recent. Hits from the cores to this set are reported through the touch port so that the recency order stays current.

The controller is a five-state machine. `ST_IDLE` waits for a miss. `ST_ISSUE` latches the current least-recent way as the candidate. `ST_WAIT` holds the query until every core has answered. `ST_FORCE` picks the least-recent way once the cap is used up. `ST_DONE` presents the victim for one cycle. The transitions are: IDLE→DONE (invalid way found, or cap of 0), IDLE→ISSUE (all ways valid, cap above 0), ISSUE→WAIT, WAIT→DONE (no core holds the candidate), WAIT→ISSUE (held, cap not reached), WAIT→FORCE (held, cap reached), FORCE→DONE and DONE→IDLE.

Top module: `qbs_victim_sel`

## Requirements
- R1: After reset, `done` and `qry_vld` are low. The recency order puts way 0 at most recent and way WAYS-1 at least recent, with the ways ranked in index order between them.
- R2: If any bit of `way_valid` is 0 when a miss is accepted, the victim is the lowest-index invalid way, `vic_binv` is 0, and no query is issued. `done` rises in the cycle after the accepting edge.
- R3: The first candidate is the least-recent way. While `qry_vld` is high, `qry_way` holds the candidate and `qry_tag` holds bits [w*TAG_W +: TAG_W] of `way_tags` for that way `w`, and both stay stable.
- R4: The decision on a candidate waits until every core has asserted its `resp_vld` bit at least once during the query. Responses may arrive in different cycles, and a core's `resp_hit` is counted only in a cycle where its `resp_vld` is high.
- R5: A candidate that no core reports as held becomes the victim, with `vic_binv` set to 0.
- R6: A candidate that any core reports as held moves to most recent, and the next query goes to the way that is then least recent.
- R7: After `query_cap` held candidates, the way that is then least recent is evicted with `vic_binv` set to 1. With a `query_cap` of 0, the least-recent way is evicted at once with `vic_binv` set to 1 and no query.
- R8: At `done`, the victim way moves to most recent.
- R9: `touch_vld` moves `touch_way` to most recent. If a touch falls in the same cycle as a promotion, both updates take effect: the promotion is applied first and the touch second.
- R10: `miss_start` is ignored while a selection is in progress, so only one `done` pulse results.
- R11: `done` is high for exactly one cycle per accepted miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_start | input | 1 | Miss strobe for this set |
| query_cap | input | CAP_W | Maximum number of presence queries per miss |
| way_valid | input | WAYS | Valid bit of each way |
| way_tags | input | WAYS*TAG_W | Tag of each way, way w at bits [w*TAG_W +: TAG_W] |
| touch_vld | input | 1 | Core hit to this set |
| touch_way | input | WAY_W | Way that was hit |
| qry_vld | output | 1 | Presence query active |
| qry_way | output | WAY_W | Candidate way being queried |
| qry_tag | output | TAG_W | Tag of the candidate |
| resp_vld | input | CORES | Per-core response strobe |
| resp_hit | input | CORES | Per-core presence flag, qualified by resp_vld |
| done | output | 1 | Victim valid, one-cycle strobe |
| vic_way | output | WAY_W | Chosen victim way |
| vic_binv | output | 1 | Victim requires back-invalidation |

## Verification
A core hit to the set, reported on the touch port, can fall in the same cycle as the last response that promotes a held candidate. In that cycle two recency updates land on the stack together. The bench provokes this by driving a touch of the way that the promotion is about to make least recent, in the same cycle as the final hit response. The outcome is judged by the way named in the next query. If both updates are applied, that way is neither the promoted way nor the touched way. Dropping either update would instead expose one of those two ways as the next candidate.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FORCE,
        ST_DONE
    } sel_state_e;
endpackage

// File: rtl/qbs_rank_stack.sv
// Full recency ranking for one set: rank 0 = most recent, WAYS-1 = least recent.
// Two move-to-front ports per cycle, applied in order: port A, then port B.
module qbs_rank_stack #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_vld,
    input  logic [WAY_W-1:0] a_way,
    input  logic             b_vld,
    input  logic [WAY_W-1:0] b_way,
    output logic [WAY_W-1:0] lru_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] rank_q   [WAYS];
    logic [WAY_W-1:0] rank_mid [WAYS];
    logic [WAY_W-1:0] rank_nxt [WAYS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rank_mid[w] = rank_q[w];
            if (a_vld) begin
                if (WAY_W'(w) == a_way)
                    rank_mid[w] = '0;
                else if (rank_q[w] < rank_q[a_way])
                    rank_mid[w] = rank_q[w] + 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            rank_nxt[w] = rank_mid[w];
            if (b_vld) begin
                if (WAY_W'(w) == b_way)
                    rank_nxt[w] = '0;
                else if (rank_mid[w] < rank_mid[b_way])
                    rank_nxt[w] = rank_mid[w] + 1'b1;
            end
        end
    end

    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (rank_q[w] == OLDEST) lru_way = WAY_W'(w);
    end

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_rank
            always_ff @(posedge clk) begin
                if (!rst_n) rank_q[g] <= WAY_W'(g);
                else        rank_q[g] <= rank_nxt[g];
            end
        end
    endgenerate
endmodule

// File: rtl/qbs_resp_collect.sv
// Gathers per-core presence answers for one outstanding query.
module qbs_resp_collect #(
    parameter int CORES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CORES-1:0] resp_vld,
    input  logic [CORES-1:0] resp_hit,
    output logic             all_in,
    output logic             any_hit
);
    logic [CORES-1:0] seen_q, held_q, seen_n, held_n;

    always_comb begin
        seen_n  = seen_q | resp_vld;
        held_n  = held_q | (resp_vld & resp_hit);
        all_in  = &seen_n;
        any_hit = |held_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen_q <= '0;
            held_q <= '0;
        end else begin
            seen_q <= seen_n;
            held_q <= held_n;
        end
    end
endmodule

// File: rtl/qbs_victim_sel.sv
module qbs_victim_sel
    import qbs_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int CORES = 4,
    parameter int TAG_W = 20,
    parameter int CAP_W = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  miss_start,
    input  logic [CAP_W-1:0]      query_cap,
    input  logic [WAYS-1:0]       way_valid,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic                  touch_vld,
    input  logic [WAY_W-1:0]      touch_way,
    output logic                  qry_vld,
    output logic [WAY_W-1:0]      qry_way,
    output logic [TAG_W-1:0]      qry_tag,
    input  logic [CORES-1:0]      resp_vld,
    input  logic [CORES-1:0]      resp_hit,
    output logic                  done,
    output logic [WAY_W-1:0]      vic_way,
    output logic                  vic_binv
);
    sel_state_e       state_q, state_d;
    logic [WAY_W-1:0] cand_q, cand_d;
    logic [WAY_W-1:0] vic_q, vic_d;
    logic             binv_q, binv_d;
    logic [CAP_W-1:0] cnt_q, cnt_d;
    logic             promote;
    logic [WAY_W-1:0] lru_way;
    logic             all_in, any_hit;
    logic             free_found;
    logic [WAY_W-1:0] free_way;
    logic             stk_a_vld;
    logic [WAY_W-1:0] stk_a_way;

    // Lowest-index invalid way.
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
    end

    // Next-state and datapath decisions.
    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        vic_d   = vic_q;
        binv_d  = binv_q;
        cnt_d   = cnt_q;
        promote = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_start) begin
                    cnt_d = '0;
                    if (free_found) begin
                        vic_d   = free_way;
                        binv_d  = 1'b0;
                        state_d = ST_DONE;
                    end else if (query_cap == '0) begin
                        vic_d   = lru_way;
                        binv_d  = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                cand_d  = lru_way;
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (all_in) begin
                    if (any_hit) begin
                        promote = 1'b1;
                        cnt_d   = cnt_q + 1'b1;
                        state_d = (cnt_d == query_cap) ? ST_FORCE : ST_ISSUE;
                    end else begin
                        vic_d   = cand_q;
                        binv_d  = 1'b0;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_FORCE: begin
                vic_d   = lru_way;
                binv_d  = 1'b1;
                state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cand_q  <= '0;
            vic_q   <= '0;
            binv_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
            vic_q   <= vic_d;
            binv_q  <= binv_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        qry_vld   = (state_q == ST_WAIT);
        qry_way   = cand_q;
        qry_tag   = way_tags[cand_q*TAG_W +: TAG_W];
        done      = (state_q == ST_DONE);
        vic_way   = vic_q;
        vic_binv  = binv_q;
        stk_a_vld = promote || (state_q == ST_DONE);
        stk_a_way = promote ? cand_q : vic_q;
    end

    qbs_rank_stack #(.WAYS(WAYS), .WAY_W(WAY_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_vld   (stk_a_vld),
        .a_way   (stk_a_way),
        .b_vld   (touch_vld),
        .b_way   (touch_way),
        .lru_way (lru_way)
    );

    qbs_resp_collect #(.CORES(CORES)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q != ST_WAIT),
        .resp_vld (resp_vld),
        .resp_hit (resp_hit),
        .all_in   (all_in),
        .any_hit  (any_hit)
    );
endmodule

// File: rtl/qbs_victim_sel_chk.sv
module qbs_victim_sel_chk #(
    parameter int WAYS  = 8,
    parameter int CAP_W = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CAP_W-1:0] query_cap,
    input logic [WAYS-1:0]  way_valid,
    input logic             qry_vld,
    input logic [WAY_W-1:0] qry_way,
    input logic             done,
    input logic             vic_binv
);
    logic           qv_d;
    logic [CAP_W:0] qcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qv_d <= 1'b0;
            qcnt <= '0;
        end else begin
            qv_d <= qry_vld;
            if (done)                qcnt <= '0;
            else if (qry_vld && !qv_d) qcnt <= qcnt + 1'b1;
        end
    end

    AST_INVALID_NO_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qry_vld) |-> &way_valid); // R2
    AST_QUERY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_vld && $past(qry_vld)) |-> $stable(qry_way)); // R3
    AST_QUERY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (qcnt <= {1'b0, query_cap})); // R7
    AST_FORCED_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vic_binv && query_cap != '0) |-> (qcnt == {1'b0, query_cap})); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
endmodule

bind qbs_victim_sel qbs_victim_sel_chk #(.WAYS(WAYS), .CAP_W(CAP_W), .WAY_W(WAY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .query_cap (query_cap),
    .way_valid (way_valid),
    .qry_vld   (qry_vld),
    .qry_way   (qry_way),
    .done      (done),
    .vic_binv  (vic_binv)
);

// File: tb/qbs_victim_sel_test.sv
module qbs_victim_sel_test;
    localparam int WAYS  = 8;
    localparam int CORES = 4;
    localparam int TAG_W = 20;
    localparam int CAP_W = 4;
    localparam int WAY_W = $clog2(WAYS);

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  miss_start;
    logic [CAP_W-1:0]      query_cap;
    logic [WAYS-1:0]       way_valid;
    logic [WAYS*TAG_W-1:0] way_tags;
    logic                  touch_vld;
    logic [WAY_W-1:0]      touch_way;
    logic                  qry_vld;
    logic [WAY_W-1:0]      qry_way;
    logic [TAG_W-1:0]      qry_tag;
    logic [CORES-1:0]      resp_vld;
    logic [CORES-1:0]      resp_hit;
    logic                  done;
    logic [WAY_W-1:0]      vic_way;
    logic                  vic_binv;

    int checks = 0;
    int fails  = 0;
    int qcount = 0;
    logic qprev = 1'b0;
    int done_seen = 0;

    always #2 clk = ~clk;

    qbs_victim_sel #(.WAYS(WAYS), .CORES(CORES), .TAG_W(TAG_W), .CAP_W(CAP_W)) uut (
        .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .query_cap(query_cap),
        .way_valid(way_valid), .way_tags(way_tags), .touch_vld(touch_vld),
        .touch_way(touch_way), .qry_vld(qry_vld), .qry_way(qry_way), .qry_tag(qry_tag),
        .resp_vld(resp_vld), .resp_hit(resp_hit), .done(done), .vic_way(vic_way),
        .vic_binv(vic_binv)
    );

    // Counts new queries and done pulses, sampled away from the active edge.
    always @(negedge clk) begin
        if (qry_vld && !qprev) qcount++;
        if (done) done_seen++;
        qprev <= qry_vld;
    end

    function automatic logic [TAG_W-1:0] tag_of(int w);
        return TAG_W'(32'h1A00 + w);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_miss();
        @(negedge clk);
        qcount    = 0;
        done_seen = 0;
        miss_start = 1'b1;
        @(negedge clk);
        miss_start = 1'b0;
    endtask

    task automatic wait_query(input int exp_way, input string req);
        int n = 0;
        while (!qry_vld && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(qry_vld, req, int'(qry_vld), 1);
        check(int'(qry_way) == exp_way, req, int'(qry_way), exp_way);
        check(qry_tag == tag_of(exp_way), req, int'(qry_tag), int'(tag_of(exp_way)));
    endtask

    // Drives all responses in one cycle, with an optional same-cycle touch.
    task automatic respond(input logic [CORES-1:0] hits, input bit tv, input int tw);
        resp_vld  = '1;
        resp_hit  = hits;
        touch_vld = tv;
        touch_way = WAY_W'(tw);
        @(negedge clk);
        resp_vld  = '0;
        resp_hit  = '0;
        touch_vld = 1'b0;
    endtask

    task automatic wait_done(input int exp_way, input bit exp_binv, input int exp_q, input string req);
        int n = 0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(done, req, int'(done), 1);
        check(int'(vic_way) == exp_way, req, int'(vic_way), exp_way);
        check(vic_binv == exp_binv, req, int'(vic_binv), int'(exp_binv));
        check(qcount == exp_q, req, qcount, exp_q);
        @(negedge clk);
        check(!done, "R11", int'(done), 0);
    endtask

    task automatic t_reset();
        check(!done && !qry_vld, "R1", int'(done) + int'(qry_vld), 0);
    endtask

    // Order after reset: 0..7, LRU 7. Way 3 invalid.
    task automatic t_invalid_first();
        way_valid = 8'b1111_0111;
        start_miss();
        check(done, "R2", int'(done), 1);
        wait_done(3, 1'b0, 0, "R2");
        way_valid = '1;
    endtask

    // Order [3,0,1,2,4,5,6,7]: LRU 7 absent.
    task automatic t_absent();
        query_cap = 4'd2;
        start_miss();
        wait_query(7, "R3");
        respond('0, 1'b0, 0);
        wait_done(7, 1'b0, 1, "R5");
    endtask

    // Order [7,3,0,1,2,4,5,6]: 6 held by core 2, then 5 absent.
    task automatic t_promote();
        start_miss();
        wait_query(6, "R6");
        respond(4'b0100, 1'b0, 0);
        wait_query(5, "R6");
        respond('0, 1'b0, 0);
        wait_done(5, 1'b0, 2, "R6");
    endtask

    // Order [5,6,7,3,0,1,2,4]: 4 held, 2 held, cap 2 -> force LRU 1.
    task automatic t_cap_reached();
        start_miss();
        wait_query(4, "R7");
        respond(4'b0001, 1'b0, 0);
        wait_query(2, "R7");
        respond(4'b1000, 1'b0, 0);
        wait_done(1, 1'b1, 2, "R7");
    endtask

    // Order [1,2,4,5,6,7,3,0]: cap 0 -> LRU 0 at once.
    task automatic t_cap_zero();
        query_cap = 4'd0;
        start_miss();
        wait_done(0, 1'b1, 0, "R7");
        query_cap = 4'd2;
    endtask

    // Order [0,1,2,4,5,6,7,3]: staggered answers for way 3, repeated miss ignored.
    task automatic t_staggered();
        start_miss();
        wait_query(3, "R4");
        resp_vld = 4'b0001; @(negedge clk);
        resp_vld = 4'b0010; miss_start = 1'b1; @(negedge clk);
        miss_start = 1'b0;
        resp_vld = 4'b0100; @(negedge clk);
        resp_vld = '0; @(negedge clk);
        check(!done, "R4", int'(done), 0);
        check(qry_vld && int'(qry_way) == 3, "R4", int'(qry_way), 3);
        resp_vld = 4'b1000; @(negedge clk);
        resp_vld = '0;
        wait_done(3, 1'b0, 1, "R4");
        repeat (4) @(negedge clk);
        check(done_seen == 1 && !qry_vld, "R10", done_seen, 1);
    endtask

    // Order [3,0,1,2,4,5,6,7]: 7 held, same cycle touch of 6 -> [6,7,3,0,1,2,4,5].
    task automatic t_concurrent();
        query_cap = 4'd3;
        start_miss();
        wait_query(7, "R9");
        respond(4'b0010, 1'b1, 6);
        wait_query(5, "R9");
        respond('0, 1'b0, 0);
        wait_done(5, 1'b0, 2, "R9");
        query_cap = 4'd2;
    endtask

    // Order [5,6,7,3,0,1,2,4]: touch 4 in idle -> LRU 2; checks victim fill too.
    task automatic t_touch_idle();
        @(negedge clk);
        touch_vld = 1'b1; touch_way = WAY_W'(4);
        @(negedge clk);
        touch_vld = 1'b0;
        start_miss();
        wait_query(2, "R9");
        respond('0, 1'b0, 0);
        wait_done(2, 1'b0, 1, "R8");
        // Order now [2,4,5,6,7,3,0,1]: LRU 1 confirms the fill of way 2.
        start_miss();
        wait_query(1, "R8");
        respond('0, 1'b0, 0);
        wait_done(1, 1'b0, 1, "R8");
    endtask

    initial begin
        rst_n = 1'b0; miss_start = 1'b0; query_cap = 4'd2; way_valid = '1;
        touch_vld = 1'b0; touch_way = '0; resp_vld = '0; resp_hit = '0;
        for (int w = 0; w < WAYS; w++) way_tags[w*TAG_W +: TAG_W] = tag_of(w);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_invalid_first();
        t_absent();
        t_promote();
        t_cap_reached();
        t_cap_zero();
        t_staggered();
        t_concurrent();
        t_touch_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule